// File: doc/BRIEF.md
# Serial Memory Command Front End with Write Latch

This block is the slave-side command decoder of a serial memory that uses SPI mode 0. The serial clock, chip select and data input are brought into the system clock domain through a two-flop synchronizer. Edges of the serial clock and of chip select are then detected on the system clock. Each chip-select low period carries one frame: an 8-bit opcode, then for memory accesses an address and data bytes, all most significant bit first. Bits are sampled on serial-clock rising edges. Read data leaves on the falling edges.

The block keeps a write-enable latch. One command sets the latch and another clears it. A write frame is accepted only while the latch is set. Its data bytes are collected into a small buffer. They reach the array only if chip select rises exactly on a byte boundary after at least one whole data byte. The commit drains the buffer as one request per byte on consecutive system clocks, and the latch clears as the commit starts. A read frame presents its address to the array port and shifts the returned bytes out. The address advances after each byte.

The controller states are Idle (chip select high), Opcode (collecting the command), Address (collecting the address), WriteData (collecting bytes), ReadData (shifting bytes out), Skip (ignoring the rest of a frame), and Commit (draining the buffer). The transitions are:
- Idle→Opcode on a chip-select fall.
- Opcode→Address after a write opcode with the latch set, or after a read opcode.
- Opcode→Skip for every other opcode, or for a write opcode with the latch clear.
- Address→WriteData or Address→ReadData after the last address bit.
- WriteData→Commit on a clean chip-select rise; WriteData→Idle on any other chip-select rise.
- Commit→Idle after the last buffered byte.
- Every other state returns to Idle when chip select rises.

Top module: `spi_cmd_front`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the latch is visible on `wel`.
- R2: Bit 3 of the opcode is ignored for memory accesses: 0x02 and 0x0A both mean write, 0x03 and 0x0B both mean read.
- R3: A write frame received while the latch is clear produces no write request.
- R4: After a clean write frame, one `wr_req` pulse is issued per data byte, in order, at addresses base, base+1, ... (modulo 2^ADDR_W), each byte assembled most significant bit first.
- R5: If chip select rises mid-byte, or before any whole data byte, the write is discarded, and the latch keeps its value.
- R6: The latch is clear after reset and clears when a write commits.
- R7: Each chip-select low period starts a fresh opcode; an aborted partial frame does not disturb the next one.
- R8: In a read, `miso` carries `rd_data` for the current address, most significant bit first. It changes only after serial-clock falling edges, it is low outside a read, and the address increments after each byte (modulo 2^ADDR_W).
- R9: Bytes beyond MAX_BYTES in one write frame are dropped; only the first MAX_BYTES are committed.
- R10: Any opcode other than the four above has no effect on the latch and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wel | output | 1 | Write-enable latch state |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data for `rd_addr` |
| wr_req | output | 1 | One-cycle commit request per byte |
| wr_addr | output | ADDR_W | Address of the committed byte |
| wr_data | output | 8 | Committed byte |

## Verification
The bench builds the block with ADDR_W = 16 and MAX_BYTES = 3. The small buffer depth lets a four-byte frame show the dropping of surplus bytes. The full 16-bit address lets a write and a read starting at 0xFFFF show the wrap to 0x0000. A serial half-period of eight system clocks leaves margin over the synchronizer delay. With that margin, partial-byte chip-select rises and aborted three-bit frames can be placed precisely.

// File: rtl/scf_pkg.sv
package scf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_WDATA,
        S_RDATA,
        S_SKIP,
        S_COMMIT
    } scf_state_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_WEN,
        C_WDIS,
        C_WR,
        C_RD
    } scf_cmd_e;

    localparam logic [7:0] OPC_WEN   = 8'h06;
    localparam logic [7:0] OPC_WDIS  = 8'h04;
    localparam logic [7:0] OPC_WR    = 8'h02;
    localparam logic [7:0] OPC_RD    = 8'h03;
    localparam logic [7:0] OPC_IGNM  = 8'hF7; // bit 3 masked for accesses

    function automatic scf_cmd_e scf_decode(input logic [7:0] op);
        if (op == OPC_WEN)                     return C_WEN;
        else if (op == OPC_WDIS)               return C_WDIS;
        else if ((op & OPC_IGNM) == OPC_WR)    return C_WR;
        else if ((op & OPC_IGNM) == OPC_RD)    return C_RD;
        else                                   return C_NONE;
    endfunction

endpackage

// File: rtl/scf_sync.sv
module scf_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta    <= RST_VAL[g];
                dout[g] <= RST_VAL[g];
            end else begin
                meta    <= din[g];
                dout[g] <= meta;
            end
        end
    end
endmodule

// File: rtl/scf_wbuf.sv
module scf_wbuf #(
    parameter int MAX_BYTES = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       dout,
    output logic [CNT_W-1:0] count
);
    logic [7:0] mem [MAX_BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (push && !clr && count == CNT_W'(i)) mem[i] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        count <= '0;
        else if (clr)                                      count <= '0;
        else if (push && count != CNT_W'(MAX_BYTES))       count <= count + 1'b1;
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (rd_idx == CNT_W'(i)) dout = mem[i];
        end
    end

    // R9: the buffer never holds more than its depth
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_BYTES));

    // R9: a push into a full buffer is dropped
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count == CNT_W'(MAX_BYTES)) |=> count == CNT_W'(MAX_BYTES));
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
    import scf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              wel,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int AC_W  = $clog2(ADDR_W + 1);

    // synchronized pins: [0] sclk, [1] chip select, [2] data in
    logic [2:0] pin_s;
    scf_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, cs_n, sclk}),
        .dout (pin_s)
    );

    logic sck_d, cs_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= pin_s[0];
            cs_d  <= pin_s[1];
        end
    end

    logic sck_rise, sck_fall, cs_rise, cs_fall, mosi_s;
    assign sck_rise = pin_s[0] & ~sck_d;
    assign sck_fall = ~pin_s[0] & sck_d;
    assign cs_rise  = pin_s[1] & ~cs_d;
    assign cs_fall  = ~pin_s[1] & cs_d;
    assign mosi_s   = pin_s[2];

    scf_state_e        state, nxt;
    logic [2:0]        bitcnt;
    logic [AC_W-1:0]   acnt;
    logic [6:0]        sh;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  widx;
    logic              is_wr, wel_q, miso_q;
    logic [7:0]        tx;
    logic [7:0]        byte_now;
    logic              byte_done;
    logic [CNT_W-1:0]  nbytes;
    logic [7:0]        buf_out;
    scf_cmd_e          cmd;

    assign byte_now  = {sh, mosi_s};
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign cmd       = scf_decode(byte_now);

    scf_wbuf #(.MAX_BYTES(MAX_BYTES)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_IDLE && cs_fall),
        .push  (state == S_WDATA && byte_done && !cs_rise),
        .din   (byte_now),
        .rd_idx(widx),
        .dout  (buf_out),
        .count (nbytes)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (cs_fall) nxt = S_OPC;
            S_OPC: begin
                if (cs_rise) nxt = S_IDLE;
                else if (byte_done) begin
                    if (cmd == C_WR)      nxt = wel_q ? S_ADDR : S_SKIP;
                    else if (cmd == C_RD) nxt = S_ADDR;
                    else                  nxt = S_SKIP;
                end
            end
            S_ADDR: begin
                if (cs_rise) nxt = S_IDLE;
                else if (sck_rise && acnt == AC_W'(ADDR_W - 1))
                    nxt = is_wr ? S_WDATA : S_RDATA;
            end
            S_WDATA: if (cs_rise)
                nxt = (bitcnt == 3'd0 && nbytes != '0) ? S_COMMIT : S_IDLE;
            S_RDATA: if (cs_rise) nxt = S_IDLE;
            S_SKIP:  if (cs_rise) nxt = S_IDLE;
            S_COMMIT: if (CNT_W'(widx + 1'b1) == nbytes) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            acnt   <= '0;
            sh     <= '0;
            addr   <= '0;
            widx   <= '0;
            is_wr  <= 1'b0;
            wel_q  <= 1'b0;
            miso_q <= 1'b0;
            tx     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (cs_fall) begin
                    bitcnt <= '0;
                    acnt   <= '0;
                    widx   <= '0;
                end
                S_OPC: if (sck_rise) begin
                    bitcnt <= bitcnt + 1'b1;
                    sh     <= byte_now[6:0];
                    if (byte_done) begin
                        if (cmd == C_WEN)  wel_q <= 1'b1;
                        if (cmd == C_WDIS) wel_q <= 1'b0;
                        is_wr <= (cmd == C_WR);
                    end
                end
                S_ADDR: if (sck_rise) begin
                    addr   <= {addr[ADDR_W-2:0], mosi_s};
                    acnt   <= acnt + 1'b1;
                    bitcnt <= '0;
                end
                S_WDATA: if (sck_rise) begin
                    bitcnt <= bitcnt + 1'b1;
                    sh     <= byte_now[6:0];
                end
                S_RDATA: begin
                    if (sck_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) addr <= addr + 1'b1;
                    end
                    if (sck_fall) begin
                        if (bitcnt == 3'd0) begin
                            miso_q <= rd_data[7];
                            tx     <= {rd_data[6:0], 1'b0};
                        end else begin
                            miso_q <= tx[7];
                            tx     <= {tx[6:0], 1'b0};
                        end
                    end
                end
                S_SKIP: ;
                S_COMMIT: widx <= widx + 1'b1;
                default: ;
            endcase
            if (state != S_RDATA) miso_q <= 1'b0;
            if (cs_rise && state != S_COMMIT && state != S_IDLE) begin
                bitcnt <= '0;
                if (nxt == S_COMMIT) begin
                    wel_q <= 1'b0;
                    widx  <= '0;
                end
            end
        end
    end

    assign miso    = miso_q;
    assign wel     = wel_q;
    assign rd_addr = addr;
    assign wr_req  = (state == S_COMMIT);
    assign wr_addr = addr + ADDR_W'(widx);
    assign wr_data = buf_out;

    // R3: the write path is only entered with the latch set
    p_wr_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && is_wr) |-> wel_q);

    // R4: every request indexes a buffered byte
    p_req_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (widx < nbytes));

    // R5: a commit only starts from a whole-byte boundary
    p_commit_whole_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_COMMIT) |-> ($past(bitcnt) == 3'd0));

    // R6: the latch is already clear while committing
    p_wel_off_in_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |-> !wel_q);

    // R7: a new frame starts with an empty bit count
    p_fresh_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_OPC) |-> (bitcnt == 3'd0));

    // R8: output is low outside a read
    p_miso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != S_RDATA) |-> !miso_q);

    // R8: output only moves after a falling serial edge
    p_miso_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDATA && $past(state) == S_RDATA && !$past(sck_fall)) |-> $stable(miso_q));
endmodule

// File: tb/tb_spi_cmd_front.sv
module tb_spi_cmd_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int AW         = 16;
    localparam int MB         = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, wel, wr_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign rd_data = model(rd_addr);

    spi_cmd_front #(.ADDR_W(AW), .MAX_BYTES(MB)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .wel(wel), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_chk = 0, n_bad = 0, ncap = 0;
    logic [AW-1:0] cap_a [8];
    logic [7:0]    cap_d [8];

    always @(negedge clk) begin
        if (rst_n && wr_req) begin
            if (ncap < 8) begin
                cap_a[ncap] = wr_addr;
                cap_d[ncap] = wr_data;
            end
            ncap++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF);
            v[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(24);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        sel(); send_byte(op); desel();
    endtask

    task automatic t_reset();
        chk("R6", "wel after reset", wel, 0);
        chk("R8", "miso after reset", miso, 0);
        chk("R4", "wr_req after reset", wr_req, 0);
    endtask

    task automatic t_latch();
        one_byte_cmd(8'h06);
        chk("R1", "wel after set cmd", wel, 1);
        one_byte_cmd(8'h04);
        chk("R1", "wel after clear cmd", wel, 0);
    endtask

    task automatic t_write_locked();
        ncap = 0;
        sel(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h10); send_byte(8'hAB); desel();
        chk("R3", "requests with latch clear", ncap, 0);
    endtask

    task automatic t_write_basic();
        ncap = 0;
        one_byte_cmd(8'h06);
        sel(); send_byte(8'h02); send_byte(8'h12); send_byte(8'h34);
        send_byte(8'hC3); send_byte(8'h5A); desel();
        chk("R4", "request count", ncap, 2);
        chk("R4", "addr0", cap_a[0], 16'h1234);
        chk("R4", "data0", cap_d[0], 8'hC3);
        chk("R4", "addr1", cap_a[1], 16'h1235);
        chk("R4", "data1", cap_d[1], 8'h5A);
        chk("R6", "wel after commit", wel, 0);
    endtask

    task automatic t_write_alt_wrap();
        ncap = 0;
        one_byte_cmd(8'h06);
        sel(); send_byte(8'h0A); send_byte(8'hFF); send_byte(8'hFF);
        send_byte(8'h11); send_byte(8'h22); desel();
        chk("R2", "alt write opcode count", ncap, 2);
        chk("R4", "wrap addr0", cap_a[0], 16'hFFFF);
        chk("R4", "wrap addr1", cap_a[1], 16'h0000);
        chk("R4", "wrap data1", cap_d[1], 8'h22);
    endtask

    task automatic t_write_partial();
        ncap = 0;
        one_byte_cmd(8'h06);
        sel(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h20);
        send_byte(8'h77); send_bits(8'hF0, 4); desel();
        chk("R5", "mid-byte rise requests", ncap, 0);
        chk("R5", "wel kept after discard", wel, 1);
        sel(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h40); desel();
        chk("R5", "no data byte requests", ncap, 0);
        chk("R5", "wel kept after empty write", wel, 1);
    endtask

    task automatic t_fresh_frame();
        ncap = 0;
        sel(); send_bits(8'hE0, 3); desel();
        sel(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h30);
        send_byte(8'h99); desel();
        chk("R7", "request after aborted frame", ncap, 1);
        chk("R7", "addr after aborted frame", cap_a[0], 16'h0030);
        chk("R7", "data after aborted frame", cap_d[0], 8'h99);
    endtask

    task automatic t_unknown();
        ncap = 0;
        one_byte_cmd(8'h06);
        sel(); send_byte(8'hC7); send_byte(8'h00); send_byte(8'h02); send_byte(8'h55); desel();
        chk("R10", "wel after unknown opcode", wel, 1);
        chk("R10", "requests after unknown opcode", ncap, 0);
        one_byte_cmd(8'h04);
    endtask

    task automatic t_overflow();
        ncap = 0;
        one_byte_cmd(8'h06);
        sel(); send_byte(8'h02); send_byte(8'h05); send_byte(8'h00);
        send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3); send_byte(8'hA4); desel();
        chk("R9", "overflow request count", ncap, MB);
        chk("R9", "last kept data", cap_d[2], 8'hA3);
        chk("R9", "last kept addr", cap_a[2], 16'h0502);
    endtask

    task automatic t_read(input logic [7:0] op, input logic [AW-1:0] a, input string req);
        logic [7:0] v;
        sel(); send_byte(op); send_byte(a[15:8]); send_byte(a[7:0]);
        get_byte(v);
        chk(req, "read byte0", v, model(a));
        get_byte(v);
        chk("R8", "read byte1", v, model(a + 1'b1));
        desel();
        chk("R8", "miso low after read", miso, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch();
        t_write_locked();
        t_write_basic();
        t_write_alt_wrap();
        t_write_partial();
        t_fresh_frame();
        t_unknown();
        t_overflow();
        t_read(8'h03, 16'h1234, "R8");
        t_read(8'h0B, 16'hFFFF, "R2");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule